// File: doc/BRIEF.md
# Four-Term Floating-Point Inner Product Unit

This block computes the inner product of two four-element vectors of IEEE 754 single-precision numbers. It produces a0*b0 + a1*b1 + a2*b2 + a3*b3 with one rounding step at the end. All four mantissa products are formed in parallel. Each product is kept as two partial vectors. All eight partial vectors are shifted to the largest product exponent and reduced to two operands. One carry-propagate addition, one normalisation and one round-to-nearest-even then give the single-precision result.

The unit is fully pipelined. It takes a new operand set on every clock in which `in_valid` is high. The matching result appears five clocks later with `out_valid` high. Lane i of each vector sits in bits [32i+31:32i] of `in_a` and `in_b`. Both operand words and the result use the standard encoding: bit 31 is the sign, bits 30:23 are the biased exponent (bias 127), and bits 22:0 are the fraction.

Top module: `fdp4_dot`

## Requirements
- R1: For normal operands, `out_result` is the exact value of the four-term sum rounded once to single precision. Bits lost off the bottom of the alignment window still count toward rounding, as a sticky bit.
- R2: An operand set taken with `in_valid` high at one clock edge gives `out_valid` high exactly five edges later. Back-to-back and gapped issue are both supported, and results come out in issue order.
- R3: A value exactly halfway between two representable results rounds to the one whose fraction LSB (bit 0) is zero. This holds for both signs.
- R4: An operand whose exponent field is 0 counts as zero, whatever its fraction bits hold.
- R5: If the rounded biased exponent is 255 or more, the result is an infinity with the sum's sign: exponent field all ones and fraction 0.
- R6: If the rounded biased exponent is 0 or less, the result is a zero with the sum's sign. An output with exponent field 0 never has a nonzero fraction.
- R7: When the products cancel exactly, the result is 0x00000000.
- R8: Reset clears `out_valid` and `out_result` to 0. `out_result` keeps its last value on every cycle where `out_valid` is low.
- R9: A product with a zero operand adds nothing to the sum and has no effect on the alignment exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_a`/`in_b` as an operand set to process |
| in_a | input | 128 | Four single-precision words, lane i in bits [32i+31:32i] |
| in_b | input | 128 | Four single-precision words, lane i in bits [32i+31:32i] |
| out_valid | output | 1 | High for one cycle per completed result |
| out_result | output | 32 | Rounded single-precision inner product |

## Verification
The bench goes after rounding ties of both signs. A unit that truncates, or that rounds ties away from zero, would return the odd neighbour. It also builds a sum whose only tie-breaker is a term far below the alignment window. A design that drops the bits it shifts out instead of keeping them as sticky would round that sum down to even. Exact cancellation, denormal operands multiplied by huge values, and zero operands next to large exponents are also covered. Each of these would leak a nonzero value or a wrong exponent if zeros were not handled cleanly. Exponent overflow and underflow of both signs are checked for correctly signed infinities and zeros. A random gapped stream shows whether results ever slip by a cycle or get out of order.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int EXP_W  = 8;
  localparam int MANT_W = 24;
  localparam int WORD_W = 1 + EXP_W + MANT_W - 1;
  localparam int PROD_W = 2 * MANT_W;
  localparam int SPLIT  = MANT_W / 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
endpackage

// File: rtl/fdp_lane_mul.sv
module fdp_lane_mul
  import fdp_pkg::*;
(
  input  logic              clk,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              neg,
  output logic [PROD_W-1:0] psum,
  output logic [PROD_W-1:0] pcar
);
  logic [MANT_W-1:0] ma, mb;

  always_comb begin
    ma = (op_a[WORD_W-2 -: EXP_W] == '0) ? '0 : {1'b1, op_a[MANT_W-2:0]};
    mb = (op_b[WORD_W-2 -: EXP_W] == '0) ? '0 : {1'b1, op_b[MANT_W-2:0]};
  end

  // product kept as two partial vectors: low and high half of mb
  always_ff @(posedge clk) begin
    neg  <= op_a[WORD_W-1] ^ op_b[WORD_W-1];
    psum <= PROD_W'(ma) * PROD_W'(mb[SPLIT-1:0]);
    pcar <= (PROD_W'(ma) * PROD_W'(mb[MANT_W-1:SPLIT])) << SPLIT;
  end
endmodule

// File: rtl/fdp_exp_diff.sv
module fdp_exp_diff
  import fdp_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                         clk,
  input  logic [LANES-1:0][EXP_W-1:0]  ea,
  input  logic [LANES-1:0][EXP_W-1:0]  eb,
  output logic [EXP_W:0]               emax,
  output logic [LANES-1:0][EXP_W:0]    shamt
);
  logic [LANES-1:0][EXP_W:0] pe;
  logic [EXP_W:0]            mx;

  always_comb begin
    mx = '0;
    for (int i = 0; i < LANES; i++) begin
      pe[i] = (ea[i] == '0 || eb[i] == '0) ? '0 : ({1'b0, ea[i]} + {1'b0, eb[i]});
      if (pe[i] > mx) mx = pe[i];
    end
  end

  always_ff @(posedge clk) begin
    emax <= mx;
    for (int i = 0; i < LANES; i++) shamt[i] <= mx - pe[i];
  end
endmodule

// File: rtl/fdp_align_reduce.sv
module fdp_align_reduce
  import fdp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int GUARD = 30,
  parameter int ACC_W = PROD_W + GUARD + 4
) (
  input  logic                           clk,
  input  logic [LANES-1:0]               neg,
  input  logic [LANES-1:0][PROD_W-1:0]   psum,
  input  logic [LANES-1:0][PROD_W-1:0]   pcar,
  input  logic [LANES-1:0][EXP_W:0]      shamt,
  input  logic [EXP_W:0]                 emax,
  output logic signed [ACC_W-1:0]        opa,
  output logic signed [ACC_W-1:0]        opb,
  output logic                           sticky,
  output logic [EXP_W:0]                 emax_q
);
  localparam int WIN = PROD_W + GUARD;

  logic [PROD_W-1:0]       v;
  logic [WIN-1:0]          ext, al;
  logic                    lost, stk;
  logic signed [ACC_W-1:0] t, sa, sb;

  always_comb begin
    sa = '0; sb = '0; stk = 1'b0;
    v = '0; ext = '0; al = '0; lost = 1'b0; t = '0;
    for (int i = 0; i < LANES; i++) begin
      for (int k = 0; k < 2; k++) begin
        v   = (k == 0) ? psum[i] : pcar[i];
        ext = {v, {GUARD{1'b0}}};
        if (int'(shamt[i]) >= WIN) begin
          al   = '0;
          lost = |v;
        end else begin
          al   = ext >> shamt[i];
          lost = |(ext & ~({WIN{1'b1}} << shamt[i]));
        end
        t = ACC_W'(al);
        if (neg[i]) t = -t;
        if (k == 0) sa = sa + t;
        else        sb = sb + t;
        stk = stk | lost;
      end
    end
  end

  always_ff @(posedge clk) begin
    opa    <= sa;
    opb    <= sb;
    sticky <= stk;
    emax_q <= emax;
  end
endmodule

// File: rtl/fdp_norm_round.sv
module fdp_norm_round
  import fdp_pkg::*;
#(
  parameter int GUARD = 30,
  parameter int ACC_W = PROD_W + GUARD + 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vin,
  input  logic signed [ACC_W-1:0] opa,
  input  logic signed [ACC_W-1:0] opb,
  input  logic                    sticky,
  input  logic [EXP_W:0]          emax,
  output logic                    out_valid,
  output logic [WORD_W-1:0]       out_result
);
  localparam int MAG_W = ACC_W - 1;
  localparam int LZ_W  = $clog2(MAG_W + 1);
  localparam int XW    = EXP_W + 4;
  localparam int EOFF  = MAG_W - 1 - BIAS - 2 * (MANT_W - 1) - GUARD;
  localparam int LB    = MAG_W - MANT_W;
  localparam logic signed [XW-1:0] EALL = XW'((1 << EXP_W) - 1);

  logic signed [ACC_W-1:0] tot;
  logic [MAG_W-1:0]        mag_c;
  logic [LZ_W-1:0]         lz_c;

  // stage 3 / 4 / 5 state
  logic                    v3, v4;
  logic                    neg3, neg4, stk3, stk4;
  logic [MAG_W-1:0]        mag3, norm4;
  logic [LZ_W-1:0]         lz3;
  logic [EXP_W:0]          em3;
  logic signed [XW-1:0]    exp4, efin;
  logic                    up;
  logic [MANT_W-1:0]       fr;
  logic [WORD_W-1:0]       res;

  always_comb begin
    tot   = opa + opb;
    mag_c = tot[ACC_W-1] ? MAG_W'(-tot) : MAG_W'(tot);
    lz_c  = LZ_W'(MAG_W);
    for (int i = 0; i < MAG_W; i++)
      if (mag_c[i]) lz_c = LZ_W'(MAG_W - 1 - i);
  end

  always_ff @(posedge clk) begin
    neg3  <= tot[ACC_W-1];
    mag3  <= mag_c;
    lz3   <= lz_c;
    stk3  <= sticky;
    em3   <= emax;
    neg4  <= neg3;
    stk4  <= stk3;
    norm4 <= mag3 << lz3;
    exp4  <= XW'(em3) - XW'(lz3) + XW'(EOFF);
  end

  always_comb begin
    up   = norm4[LB - 1] & ((|norm4[LB-2:0]) | stk4 | norm4[LB]);
    fr   = {1'b0, norm4[MAG_W-2 -: MANT_W-1]} + MANT_W'(up);
    efin = exp4 + {{(XW-1){1'b0}}, fr[MANT_W-1]};
    if (!norm4[MAG_W-1])
      res = '0;
    else if (!efin[XW-1] && efin >= EALL)
      res = {neg4, {EXP_W{1'b1}}, {(MANT_W-1){1'b0}}};
    else if (efin[XW-1] || efin == '0)
      res = {neg4, {(WORD_W-1){1'b0}}};
    else
      res = {neg4, efin[EXP_W-1:0], fr[MANT_W-2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v3 <= 1'b0; v4 <= 1'b0; out_valid <= 1'b0; out_result <= '0;
    end else begin
      v3 <= vin;
      v4 <= v3;
      out_valid <= v4;
      if (v4) out_result <= res;
    end
  end
endmodule

// File: rtl/fdp4_dot.sv
module fdp4_dot
  import fdp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int GUARD = 30
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [LANES*WORD_W-1:0]   in_a,
  input  logic [LANES*WORD_W-1:0]   in_b,
  output logic                      out_valid,
  output logic [WORD_W-1:0]         out_result
);
  localparam int ACC_W = PROD_W + GUARD + $clog2(2 * LANES) + 1;

  logic [LANES-1:0][WORD_W-1:0] a_arr, b_arr;
  logic [LANES-1:0][EXP_W-1:0]  ea, eb;
  logic [LANES-1:0]             l_neg;
  logic [LANES-1:0][PROD_W-1:0] l_sum, l_car;
  logic [LANES-1:0][EXP_W:0]    shamt;
  logic [EXP_W:0]               emax1, emax2;
  logic signed [ACC_W-1:0]      opa, opb;
  logic                         stk2;
  logic                         v1, v2;

  assign a_arr = in_a;
  assign b_arr = in_b;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign ea[i] = a_arr[i][WORD_W-2 -: EXP_W];
    assign eb[i] = b_arr[i][WORD_W-2 -: EXP_W];
    fdp_lane_mul u_mul (
      .clk (clk), .op_a(a_arr[i]), .op_b(b_arr[i]),
      .neg (l_neg[i]), .psum(l_sum[i]), .pcar(l_car[i])
    );
  end

  fdp_exp_diff #(.LANES(LANES)) u_exp (
    .clk(clk), .ea(ea), .eb(eb), .emax(emax1), .shamt(shamt)
  );

  fdp_align_reduce #(.LANES(LANES), .GUARD(GUARD), .ACC_W(ACC_W)) u_align (
    .clk(clk), .neg(l_neg), .psum(l_sum), .pcar(l_car), .shamt(shamt),
    .emax(emax1), .opa(opa), .opb(opb), .sticky(stk2), .emax_q(emax2)
  );

  fdp_norm_round #(.GUARD(GUARD), .ACC_W(ACC_W)) u_round (
    .clk(clk), .rst(rst), .vin(v2), .opa(opa), .opb(opb), .sticky(stk2),
    .emax(emax2), .out_valid(out_valid), .out_result(out_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end
endmodule

// File: rtl/fdp4_dot_chk.sv
module fdp4_dot_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        out_valid,
  input logic [31:0] out_result
);
  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R2: fixed five-cycle latency, one result per accepted operand set
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd6) |-> (out_valid == $past(in_valid, 5)));

  // R5: overflow gives a clean infinity, never a NaN pattern
  a_r5_inf_clean: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_result[30:23] == 8'hFF) |-> (out_result[22:0] == '0));

  // R6: no denormal results
  a_r6_no_denormal: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_result[30:23] == 8'h00) |-> (out_result[22:0] == '0));

  // R8: result held while no valid
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_result));
endmodule

bind fdp4_dot fdp4_dot_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/tb_fdp4_dot.sv
module tb_fdp4_dot;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_a = '0, in_b = '0;
  logic         out_valid;
  logic [31:0]  out_result;

  int    checks = 0, fails = 0;
  bit    done = 1'b0;
  string cur_tag = "";
  bit    cur_ovr = 1'b0;
  logic [31:0] cur_ovv = '0;

  bit          exp_v [5];
  logic [31:0] exp_r [5];
  string       exp_t [5];
  bit          have_last = 1'b0;
  logic [31:0] last_r = '0;

  always #4 clk = ~clk;

  fdp4_dot dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a),
                .in_b(in_b), .out_valid(out_valid), .out_result(out_result));

  function automatic real f2r(input logic [31:0] x);
    logic [10:0] e11;
    if (x[30:23] == 8'h00) return 0.0;
    e11 = {3'b0, x[30:23]} + 11'd896;
    return $bitstoreal({x[31], e11, x[22:0], 29'b0});
  endfunction

  function automatic logic [31:0] r2f(input real r);
    logic [63:0] bt;
    int          e;
    logic [24:0] m;
    if (r == 0.0) return 32'h0;
    bt = $realtobits(r);
    e  = int'(bt[62:52]) - 896;
    m  = {2'b01, bt[51:29]};
    if (bt[28] && ((|bt[27:0]) || m[0])) m = m + 25'd1;
    if (m[24]) begin e++; m = m >> 1; end
    if (e >= 255) return {bt[63], 8'hFF, 23'h0};
    if (e <= 0)   return {bt[63], 31'h0};
    return {bt[63], 8'(e), m[22:0]};
  endfunction

  function automatic logic [31:0] ref_dot(input logic [127:0] a, input logic [127:0] b);
    real s = 0.0;
    for (int i = 0; i < 4; i++) s = s + f2r(a[32*i +: 32]) * f2r(b[32*i +: 32]);
    return r2f(s);
  endfunction

  function automatic logic [31:0] rnd_word();
    if ($urandom % 16 == 0) return 32'h0;
    return {1'($urandom), 8'(122 + $urandom_range(10, 0)), 11'($urandom), 12'h0};
  endfunction

  // behavioural reference pipeline
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 5; i++) exp_v[i] <= 1'b0;
    end else begin
      for (int i = 4; i > 0; i--) begin
        exp_v[i] <= exp_v[i-1]; exp_r[i] <= exp_r[i-1]; exp_t[i] <= exp_t[i-1];
      end
      exp_v[0] <= in_valid;
      exp_r[0] <= cur_ovr ? cur_ovv : ref_dot(in_a, in_b);
      exp_t[0] <= cur_tag;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (out_valid !== exp_v[4]) begin
        fails++;
        $display("FAIL R2 valid timing: out_valid=%b expected %b", out_valid, exp_v[4]);
      end
      if (exp_v[4]) begin
        checks++;
        if (out_result !== exp_r[4]) begin
          fails++;
          $display("FAIL %s: out_result=%h expected %h", exp_t[4], out_result, exp_r[4]);
        end
        have_last = 1'b1;
        last_r = exp_r[4];
      end else if (have_last) begin
        checks++;
        if (out_result !== last_r) begin
          fails++;
          $display("FAIL R8 hold: out_result=%h expected %h", out_result, last_r);
        end
      end
    end
  end

  task automatic issue(input logic [31:0] a0, a1, a2, a3, b0, b1, b2, b3,
                       input string tag, input bit ovr = 1'b0, input logic [31:0] ovv = '0);
    @(negedge clk);
    in_valid = 1'b1;
    in_a = {a3, a2, a1, a0};
    in_b = {b3, b2, b1, b0};
    cur_tag = tag; cur_ovr = ovr; cur_ovv = ovv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; cur_ovr = 1'b0;
    end
  endtask

  localparam logic [31:0] ONE = 32'h3F800000, Z = 32'h0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (out_valid !== 1'b0 || out_result !== 32'h0) begin
      fails++;
      $display("FAIL R8 reset: out_valid=%b out_result=%h expected 0 00000000", out_valid, out_result);
    end
    // R1 plain sums
    issue(ONE, 32'h40000000, 32'h40400000, 32'h40800000,
          32'h40A00000, 32'h40C00000, 32'h40E00000, 32'h41000000, "R1 integer dot");
    issue(32'hBFC00000, 32'h3E800000, ONE, 32'hC1200000,
          32'h40000000, 32'h41800000, 32'h3F000000, 32'h3DCCCCCD, "R1 mixed signs");
    // R3 ties
    issue(ONE, 32'h39800000, Z, Z, ONE, 32'h39800000, Z, Z, "R3 tie to even down");
    issue(32'h3F800001, 32'h39800000, Z, Z, ONE, 32'h39800000, Z, Z, "R3 tie to even up");
    issue(32'hBF800000, 32'hB9800000, Z, Z, ONE, 32'h39800000, Z, Z, "R3 negative tie");
    issue(ONE, 32'h39800000, 32'h38000000, Z, ONE, 32'h39800000, 32'h38000000, Z, "R3 just above tie");
    // R1 sticky from a term below the window: exact value is above the tie
    issue(ONE, 32'h39800000, 32'h26800000, Z, ONE, 32'h39800000, 32'h26800000, Z,
          "R1 sticky below window", 1'b1, 32'h3F800001);
    // R4 denormal operands
    issue(32'h00000001, ONE, Z, Z, ONE, ONE, Z, Z, "R4 denormal plus one");
    issue(32'h007FFFFF, Z, Z, Z, 32'h7E800000, Z, Z, Z, "R4 denormal times huge");
    // R5 overflow
    issue(32'h71800000, Z, Z, Z, 32'h71800000, Z, Z, Z, "R5 positive infinity", 1'b1, 32'h7F800000);
    issue(32'hF1800000, Z, Z, Z, 32'h71800000, Z, Z, Z, "R5 negative infinity", 1'b1, 32'hFF800000);
    // R6 underflow
    issue(32'h0D800000, Z, Z, Z, 32'h0D800000, Z, Z, Z, "R6 positive underflow", 1'b1, 32'h00000000);
    issue(32'h8D800000, Z, Z, Z, 32'h0D800000, Z, Z, Z, "R6 negative underflow", 1'b1, 32'h80000000);
    // R7 cancellation
    issue(ONE, 32'hBF800000, Z, Z, ONE, ONE, Z, Z, "R7 exact cancel", 1'b1, 32'h00000000);
    issue(32'h3FC00000, 32'hC0400000, ONE, 32'hBF800000,
          32'h40000000, ONE, 32'h40000000, 32'h40000000, "R7 four-term cancel", 1'b1, 32'h00000000);
    // R9 zero operands beside big exponents
    issue(Z, 32'h35800000, Z, Z, 32'h7E800000, ONE, Z, Z, "R9 zero times huge", 1'b1, 32'h35800000);
    issue(32'h7E800000, Z, Z, Z, Z, Z, Z, Z, "R9 all products zero", 1'b1, 32'h00000000);
    idle(8);
    // R2/R1 random stream with gaps
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 4 != 0)
        issue(rnd_word(), rnd_word(), rnd_word(), rnd_word(),
              rnd_word(), rnd_word(), rnd_word(), rnd_word(), "R1 R2 random stream");
      else idle(1);
    end
    idle(12);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL R2 watchdog: run hung, actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule